// File: doc/BRIEF.md
# CPU Memory Window Decoder

This block sits on the CPU side of a cartridge-style memory system. It takes each CPU address in the range 0x4800 to 0x7FFF and sends it to one of three targets: an 8 KiB on-chip RAM, a 32 KiB external PRG-RAM, or the external PRG-ROM. For the selected target it produces a banked address, and it produces write enables for the two writable targets. Read data from the selected target is returned to the CPU. All routing is combinational, so an access is decoded in the cycle in which it is presented.

Three windows overlap on the same on-chip RAM. A 2 KiB window always shows the bottom of the RAM. A 4 KiB window shows one half of the RAM, and a register selects the half. A boot strap input replaces this window with a fixed ROM bank. The upper 8 KiB window is driven by a bank register. The top two bits of that register choose external RAM, the whole on-chip RAM, or ROM. Two write-only registers hold this state. They change on the clock edge that ends a CPU write to them, and all other control addresses between 0x4100 and 0x4161 stay outside every window.

Top module: `mem_window_dec`

## Requirements
- R1: After reset both window registers are zero. An access at 0x5000-0x5FFF then targets on-chip RAM half 0, and an access at 0x6000-0x7FFF targets PRG-RAM bank 0.
- R2: Addresses 0x4800-0x4FFF target the on-chip RAM at address A[10:0], with the upper address bits zero. This holds whatever the register contents are.
- R3: A write to 0x4123 stores data bit 0 as the half select. While the boot strap is low, 0x5000-0x5FFF then targets on-chip RAM address {half, A[11:0]}.
- R4: While the boot strap input is high, 0x5000-0x5FFF targets PRG-ROM at address 125*4096 + A[11:0], and a write there asserts no write enable.
- R5: A write to 0x4124 stores data bits 5..0 as the window bank and bits 7..6 as the chip select. The new values steer accesses from the next clock cycle onward.
- R6: With chip select 0, 0x6000-0x7FFF targets PRG-RAM at address {bank[1:0], A[12:0]}.
- R7: With chip select 1, 0x6000-0x7FFF targets the whole on-chip RAM at address A[12:0].
- R8: With chip select 2 or 3, 0x6000-0x7FFF targets PRG-ROM at address {bank[5:0], A[12:0]}. A write there asserts neither write enable.
- R9: The target code is 0 for none, 1 for on-chip RAM, 2 for PRG-RAM and 3 for PRG-ROM. The on-chip RAM write enable is high only for a CPU write with code 1. The PRG-RAM write enable is high only for a CPU write with code 2.
- R10: CPU read data equals the on-chip RAM read data for code 1 and the external read data for codes 2 and 3. It is 0x00, with code 0, for every other address, including the control registers 0x4100-0x4161.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the window registers |
| boot_mode | input | 1 | Boot strap; replaces the 4 KiB window with the fixed ROM bank |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe for the current cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational |
| tgt_sel | output | 2 | Target code: 0 none, 1 on-chip RAM, 2 PRG-RAM, 3 PRG-ROM |
| ocram_addr | output | 13 | On-chip RAM address |
| ocram_we | output | 1 | On-chip RAM write enable |
| ocram_rdata | input | 8 | On-chip RAM read data |
| prgram_addr | output | 15 | PRG-RAM address |
| prgram_we | output | 1 | PRG-RAM write enable |
| prgrom_addr | output | 19 | PRG-ROM address |
| ext_rdata | input | 8 | Read data from external PRG-RAM or PRG-ROM |

## Verification
The only internal state is the half select, the window bank and the chip select. A wrong value in any of them shows at the ports in the first access to the affected window after the register write that set it: the target code changes, the banked address bits change, or a write enable is wrong. The bench probes each window with the bench clock low, right after every register write, and also checks that a write with ROM selected asserts no enable. Each target returns read data derived from its own address, so a fault in the read-data select cannot match by chance.

// File: rtl/win_pkg.sv
package win_pkg;

   typedef enum logic [1:0] {
      TGT_NONE   = 2'd0,
      TGT_OCRAM  = 2'd1,
      TGT_PRGRAM = 2'd2,
      TGT_PRGROM = 2'd3
   } tgt_e;

   typedef enum logic [1:0] {
      CS_PRGRAM = 2'd0,
      CS_OCRAM  = 2'd1,
      CS_ROM_LO = 2'd2,
      CS_ROM_HI = 2'd3
   } cs_e;

   localparam logic [15:0] REG_HALF_ADDR = 16'h4123;
   localparam logic [15:0] REG_BANK_ADDR = 16'h4124;
   localparam logic [15:0] CTRL_LO       = 16'h4100;
   localparam logic [15:0] CTRL_HI       = 16'h4161;

endpackage

// File: rtl/win_regs.sv
module win_regs
   import win_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int BANK_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              half_sel,
   output logic [BANK_W-1:0] win_bank,
   output cs_e               win_cs
);

   localparam int CS_LSB = DATA_W - 2;

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("win_regs: DATA_W must be 8");
      end
      if (BANK_W < 1 || BANK_W > CS_LSB) begin : g_bad_bank
         $error("win_regs: BANK_W must fit below the chip select bits");
      end
   endgenerate

   logic hit_half, hit_bank;
   assign hit_half = cpu_wr && (cpu_addr == ADDR_W'(REG_HALF_ADDR));
   assign hit_bank = cpu_wr && (cpu_addr == ADDR_W'(REG_BANK_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_sel <= 1'b0;
         win_bank <= '0;
         win_cs   <= CS_PRGRAM;
      end else begin
         if (hit_half) half_sel <= cpu_wdata[0];
         if (hit_bank) begin
            win_bank <= cpu_wdata[BANK_W-1:0];
            win_cs   <= cs_e'(cpu_wdata[DATA_W-1:CS_LSB]);
         end
      end
   end

   // R1: registers start from zero
   assert_reset_clear_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!half_sel && win_bank == '0 && win_cs == CS_PRGRAM));

   // R5: a bank register write lands in the next cycle
   assert_bank_load_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == ADDR_W'(REG_BANK_ADDR)) |=>
         (win_bank == $past(cpu_wdata[BANK_W-1:0]) &&
          win_cs == cs_e'($past(cpu_wdata[DATA_W-1:CS_LSB]))));

   // R3: a half register write lands in the next cycle
   assert_half_load_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == ADDR_W'(REG_HALF_ADDR)) |=>
         (half_sel == $past(cpu_wdata[0])));

endmodule

// File: rtl/win_route.sv
module win_route
   import win_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int BANK_W    = 6,
   parameter int OC_AW     = 13,
   parameter int PRAM_AW   = 15,
   parameter int PROM_AW   = 19,
   parameter int BOOT_BANK = 125,
   parameter bit BOOT_EN   = 1'b1
) (
   input  logic               boot_mode,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic               cpu_wr,
   input  logic               half_sel,
   input  logic [BANK_W-1:0]  win_bank,
   input  cs_e                win_cs,
   output tgt_e               tgt,
   output logic [OC_AW-1:0]   ocram_addr,
   output logic               ocram_we,
   output logic [PRAM_AW-1:0] prgram_addr,
   output logic               prgram_we,
   output logic [PROM_AW-1:0] prgrom_addr
);

   localparam int WIN8_AW = 13;
   localparam int WIN4_AW = 12;
   localparam int WIN2_AW = 11;
   localparam int PB_W    = PRAM_AW - WIN8_AW;
   localparam logic [PROM_AW-1:0] BOOT_BASE = PROM_AW'(BOOT_BANK) << WIN4_AW;

   generate
      if (ADDR_W != 16) begin : g_bad_addr
         $error("win_route: ADDR_W must be 16");
      end
      if (OC_AW != WIN8_AW) begin : g_bad_oc
         $error("win_route: on-chip RAM must be 8 KiB");
      end
      if (PB_W < 1 || PB_W > BANK_W) begin : g_bad_pram
         $error("win_route: PRAM_AW out of range");
      end
      if (PROM_AW < BANK_W + WIN8_AW) begin : g_bad_prom
         $error("win_route: PROM_AW too narrow for bank");
      end
      if (BOOT_BANK < 0 || BOOT_BANK >= (1 << (PROM_AW - WIN4_AW))) begin : g_bad_boot
         $error("win_route: BOOT_BANK out of range");
      end
   endgenerate

   logic boot_act;
   generate
      if (BOOT_EN) begin : g_boot
         assign boot_act = boot_mode;
      end else begin : g_noboot
         logic unused_boot;
         assign unused_boot = boot_mode;
         assign boot_act    = 1'b0;
      end
   endgenerate

   logic in_win2, in_win4, in_win8;
   assign in_win2 = (cpu_addr[15:11] == 5'b01001);
   assign in_win4 = (cpu_addr[15:12] == 4'b0101);
   assign in_win8 = (cpu_addr[15:13] == 3'b011);

   always_comb begin
      tgt         = TGT_NONE;
      ocram_addr  = '0;
      prgram_addr = '0;
      prgrom_addr = '0;
      if (in_win2) begin
         tgt        = TGT_OCRAM;
         ocram_addr = OC_AW'(cpu_addr[WIN2_AW-1:0]);
      end else if (in_win4) begin
         if (boot_act) begin
            tgt         = TGT_PRGROM;
            prgrom_addr = BOOT_BASE | PROM_AW'(cpu_addr[WIN4_AW-1:0]);
         end else begin
            tgt        = TGT_OCRAM;
            ocram_addr = OC_AW'({half_sel, cpu_addr[WIN4_AW-1:0]});
         end
      end else if (in_win8) begin
         unique case (win_cs)
            CS_PRGRAM: begin
               tgt         = TGT_PRGRAM;
               prgram_addr = {win_bank[PB_W-1:0], cpu_addr[WIN8_AW-1:0]};
            end
            CS_OCRAM: begin
               tgt        = TGT_OCRAM;
               ocram_addr = cpu_addr[WIN8_AW-1:0];
            end
            default: begin
               tgt         = TGT_PRGROM;
               prgrom_addr = PROM_AW'({win_bank, cpu_addr[WIN8_AW-1:0]});
            end
         endcase
      end
   end

   assign ocram_we  = cpu_wr && (tgt == TGT_OCRAM);
   assign prgram_we = cpu_wr && (tgt == TGT_PRGRAM);

endmodule

// File: rtl/win_rmux.sv
module win_rmux
   import win_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  tgt_e              tgt,
   input  logic [DATA_W-1:0] ocram_rdata,
   input  logic [DATA_W-1:0] ext_rdata,
   output logic [DATA_W-1:0] cpu_rdata
);

   always_comb begin
      unique case (tgt)
         TGT_OCRAM:              cpu_rdata = ocram_rdata;
         TGT_PRGRAM, TGT_PRGROM: cpu_rdata = ext_rdata;
         default:                cpu_rdata = '0;
      endcase
   end

endmodule

// File: rtl/mem_window_dec.sv
module mem_window_dec
   import win_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int BANK_W    = 6,
   parameter int OC_AW     = 13,
   parameter int PRAM_AW   = 15,
   parameter int PROM_AW   = 19,
   parameter int BOOT_BANK = 125,
   parameter bit BOOT_EN   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               boot_mode,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic               cpu_wr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic [DATA_W-1:0]  cpu_rdata,
   output logic [1:0]         tgt_sel,
   output logic [OC_AW-1:0]   ocram_addr,
   output logic               ocram_we,
   input  logic [DATA_W-1:0]  ocram_rdata,
   output logic [PRAM_AW-1:0] prgram_addr,
   output logic               prgram_we,
   output logic [PROM_AW-1:0] prgrom_addr,
   input  logic [DATA_W-1:0]  ext_rdata
);

   logic              half_sel;
   logic [BANK_W-1:0] win_bank;
   cs_e               win_cs;
   tgt_e              tgt;

   win_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BANK_W (BANK_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_addr  (cpu_addr),
      .cpu_wr    (cpu_wr),
      .cpu_wdata (cpu_wdata),
      .half_sel  (half_sel),
      .win_bank  (win_bank),
      .win_cs    (win_cs)
   );

   win_route #(
      .ADDR_W    (ADDR_W),
      .BANK_W    (BANK_W),
      .OC_AW     (OC_AW),
      .PRAM_AW   (PRAM_AW),
      .PROM_AW   (PROM_AW),
      .BOOT_BANK (BOOT_BANK),
      .BOOT_EN   (BOOT_EN)
   ) i_route (
      .boot_mode   (boot_mode),
      .cpu_addr    (cpu_addr),
      .cpu_wr      (cpu_wr),
      .half_sel    (half_sel),
      .win_bank    (win_bank),
      .win_cs      (win_cs),
      .tgt         (tgt),
      .ocram_addr  (ocram_addr),
      .ocram_we    (ocram_we),
      .prgram_addr (prgram_addr),
      .prgram_we   (prgram_we),
      .prgrom_addr (prgrom_addr)
   );

   win_rmux #(
      .DATA_W (DATA_W)
   ) i_rmux (
      .tgt         (tgt),
      .ocram_rdata (ocram_rdata),
      .ext_rdata   (ext_rdata),
      .cpu_rdata   (cpu_rdata)
   );

   assign tgt_sel = tgt;

   // R2: small window always reaches the RAM bottom
   assert_low_win_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:11] == 5'b01001) |->
         (tgt_sel == 2'd1 && ocram_addr == OC_AW'(cpu_addr[10:0])));

   // R4: boot strap diverts the 4 KiB window to ROM
   assert_boot_rom_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (BOOT_EN && boot_mode && cpu_addr[15:12] == 4'h5) |->
         (tgt_sel == 2'd3 && !ocram_we && !prgram_we));

   // R8: ROM target never sees a write enable
   assert_rom_no_we_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_sel == 2'd3) |-> (!ocram_we && !prgram_we));

   // R9: write enables only follow a CPU write
   assert_we_src_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (ocram_we || prgram_we) |-> cpu_wr);

   // R10: control registers read back as zero
   assert_ctrl_zero_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr >= ADDR_W'(CTRL_LO) && cpu_addr <= ADDR_W'(CTRL_HI)) |->
         (tgt_sel == 2'd0 && cpu_rdata == '0));

endmodule

// File: tb/test_mem_window_dec.sv
module test_mem_window_dec;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_mode = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = 8'h00;
   logic [7:0]  cpu_rdata;
   logic [1:0]  tgt_sel;
   logic [12:0] ocram_addr;
   logic        ocram_we;
   logic [7:0]  ocram_rdata;
   logic [14:0] prgram_addr;
   logic        prgram_we;
   logic [18:0] prgrom_addr;
   logic [7:0]  ext_rdata;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // Memory models: read data derived from the address of the selected target
   assign ocram_rdata = ocram_addr[7:0] ^ 8'hA5;
   assign ext_rdata   = (tgt_sel == 2'd2) ? (prgram_addr[7:0] ^ 8'h3C)
                                          : (prgrom_addr[7:0] ^ 8'h3C);

   mem_window_dec i_mem_window_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .boot_mode   (boot_mode),
      .cpu_addr    (cpu_addr),
      .cpu_wr      (cpu_wr),
      .cpu_wdata   (cpu_wdata),
      .cpu_rdata   (cpu_rdata),
      .tgt_sel     (tgt_sel),
      .ocram_addr  (ocram_addr),
      .ocram_we    (ocram_we),
      .ocram_rdata (ocram_rdata),
      .prgram_addr (prgram_addr),
      .prgram_we   (prgram_we),
      .prgrom_addr (prgrom_addr),
      .ext_rdata   (ext_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Register write: held across one rising edge
   task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr  = a;
      cpu_wdata = d;
      cpu_wr    = 1'b1;
      @(negedge clk);
      cpu_wr    = 1'b0;
      cpu_addr  = 16'h0000;
   endtask

   // Probe one access combinationally, before the next rising edge
   task automatic probe(input string tag, input logic [15:0] a, input bit wr,
                        input logic [1:0] exp_tgt, input logic [31:0] exp_addr);
      logic [7:0] exp_rd;
      @(negedge clk);
      cpu_addr  = a;
      cpu_wdata = 8'h5A;
      cpu_wr    = wr;
      #1;
      chk({tag, " target"}, 32'(tgt_sel), 32'(exp_tgt));
      case (exp_tgt)
         2'd1: chk({tag, " ocram addr"}, 32'(ocram_addr), exp_addr);
         2'd2: chk({tag, " prgram addr"}, 32'(prgram_addr), exp_addr);
         2'd3: chk({tag, " prgrom addr"}, 32'(prgrom_addr), exp_addr);
         default: ;
      endcase
      chk({tag, " R9 ocram_we"}, 32'(ocram_we), 32'(wr && exp_tgt == 2'd1));
      chk({tag, " R9 prgram_we"}, 32'(prgram_we), 32'(wr && exp_tgt == 2'd2));
      if (!wr) begin
         case (exp_tgt)
            2'd1:       exp_rd = exp_addr[7:0] ^ 8'hA5;
            2'd2, 2'd3: exp_rd = exp_addr[7:0] ^ 8'h3C;
            default:    exp_rd = 8'h00;
         endcase
         chk({tag, " R10 rdata"}, 32'(cpu_rdata), 32'(exp_rd));
      end
      cpu_wr = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      probe("R1 half0", 16'h5123, 1'b0, 2'd1, 32'h0123);
      probe("R1 prgram bank0", 16'h6456, 1'b0, 2'd2, 32'h0456);
      probe("R1 prgram top", 16'h7FFF, 1'b0, 2'd2, 32'h1FFF);
   endtask

   task automatic t_low_window();
      probe("R2 low base", 16'h4800, 1'b0, 2'd1, 32'h0000);
      probe("R2 low top", 16'h4FFF, 1'b0, 2'd1, 32'h07FF);
      probe("R2 low write", 16'h4A55, 1'b1, 2'd1, 32'h0255);
   endtask

   task automatic t_half_window();
      reg_write(16'h4123, 8'h01);
      probe("R3 half1", 16'h5234, 1'b0, 2'd1, 32'h1234);
      probe("R3 half1 write", 16'h5FFF, 1'b1, 2'd1, 32'h1FFF);
      probe("R2 low ignores half", 16'h4C01, 1'b0, 2'd1, 32'h0401);
      reg_write(16'h4123, 8'hFE);
      probe("R3 half0 bit0 only", 16'h5234, 1'b0, 2'd1, 32'h0234);
   endtask

   task automatic t_boot();
      reg_write(16'h4123, 8'h01);
      boot_mode = 1'b1;
      probe("R4 boot rom", 16'h5ABC, 1'b0, 2'd3, 32'h7DABC);
      probe("R4 boot write", 16'h5000, 1'b1, 2'd3, 32'h7D000);
      probe("R4 boot low unaffected", 16'h4900, 1'b0, 2'd1, 32'h0100);
      boot_mode = 1'b0;
      probe("R4 boot release", 16'h5ABC, 1'b0, 2'd1, 32'h1ABC);
   endtask

   task automatic t_big_window();
      reg_write(16'h4124, 8'h07);
      probe("R6 bank3", 16'h7FFF, 1'b0, 2'd2, 32'h7FFF);
      probe("R6 bank3 write", 16'h6001, 1'b1, 2'd2, 32'h6001);
      reg_write(16'h4124, 8'h45);
      probe("R7 ocram full", 16'h7123, 1'b0, 2'd1, 32'h1123);
      probe("R7 ocram write", 16'h6010, 1'b1, 2'd1, 32'h0010);
      reg_write(16'h4124, 8'hBF);
      probe("R8 rom cs2", 16'h6010, 1'b0, 2'd3, 32'h7E010);
      probe("R8 rom cs2 write", 16'h7FFE, 1'b1, 2'd3, 32'h7FFFE);
      reg_write(16'h4124, 8'hC1);
      probe("R8 rom cs3", 16'h7000, 1'b0, 2'd3, 32'h03000);
      probe("R8 rom cs3 write", 16'h6000, 1'b1, 2'd3, 32'h02000);
      reg_write(16'h4124, 8'h02);
      probe("R5 back to prgram", 16'h6100, 1'b0, 2'd2, 32'h4100);
   endtask

   task automatic t_unmapped();
      probe("R10 ctrl lo", 16'h4100, 1'b0, 2'd0, 32'h0);
      probe("R10 ctrl hi", 16'h4161, 1'b0, 2'd0, 32'h0);
      probe("R10 half reg", 16'h4123, 1'b0, 2'd0, 32'h0);
      probe("R10 below low", 16'h47FF, 1'b0, 2'd0, 32'h0);
      probe("R10 above", 16'h8000, 1'b0, 2'd0, 32'h0);
      probe("R10 zero", 16'h0000, 1'b0, 2'd0, 32'h0);
   endtask

   task automatic t_reset_again();
      reg_write(16'h4123, 8'h01);
      reg_write(16'h4124, 8'hFF);
      do_reset();
      probe("R1 reset half", 16'h5010, 1'b0, 2'd1, 32'h0010);
      probe("R1 reset bank", 16'h6010, 1'b0, 2'd2, 32'h0010);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_low_window();
      t_half_window();
      t_boot();
      t_big_window();
      t_unmapped();
      t_reset_again();
      repeat (2) @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule